// File: doc/BRIEF.md
# Serial Configuration Register Port for a Six-Channel Audio DAC

This block is the write-only control port of a six-channel audio converter. An external controller drives three slow pins: a serial clock, a serial data line and a latch strobe. The block brings all three into the system clock domain through two-flop synchronisers and finds their rising edges. It shifts one data bit in on each rising edge of the serial clock, most significant bit first. When the latch rises after exactly sixteen bits, it decodes the word and updates one of nine configuration registers.

A word has three parts. The top nibble (bits 15:12) picks the target register. Bits 11:10 are reserved and carry no meaning. The low ten bits (9:0) are the payload. The decoded fields leave the block as plain outputs that the datapath reads:

- de-emphasis curve
- serial input format
- word width
- power-down
- interpolation ratio
- one mute per channel
- one 10-bit linear volume per channel
- stereo replication
- master-clock multiplier
- zero-flag polarity
- TDM clock direction

Each accepted write also produces a single-cycle strobe together with the address that was written.

Top module: `dac_cfg_port`

## Requirements
- R1: A word is 16 bits, taken most significant bit first, with one bit sampled on each rising edge of `scl_i`. Bits 15:12 are the register address and bits 9:0 are the payload.
- R2: Register outputs change only as the result of an accepted latch. While bits are being shifted in, every output holds its value.
- R3: A latch rise is accepted only when exactly 16 serial-clock rises have occurred since the previous latch rise or since reset. With 15 bits or 17 bits, nothing is written and no strobe is produced.
- R4: Addresses 9 to 15 are reserved. A word sent to any of them is ignored: no register changes and no strobe is produced.
- R5: Address 0 loads the first control register, which is split into these fields:
  - `deemph_o` from bits 9:8
  - `fmt_o` from bits 7:5
  - `width_o` from bits 4:3
  - `pdown_o` from bit 2
  - `interp_o` from bits 1:0
- R6: Address 1 loads `mute_o` from bits 5:0. Bit n mutes channel n+1, and 1 means muted.
- R7: Addresses 2 to 7 load the volumes of channels 1 to 6 in that order. Channel k occupies bits `10*k-1 : 10*(k-1)` of `vol_o`.
- R8: Address 8 loads the third control register, which is split into these fields:
  - `replicate_o` from bit 5
  - `mclk_sel_o` from bits 4:3
  - `zero_pol_o` from bit 2
  - `tdm_slave_o` from bit 0
- R9: Reset clears every control field and every mute to 0, and sets every volume to 10'h3FF.
- R10: Each accepted write drives `wr_stb_o` high for exactly one cycle, with `wr_addr_o` holding the address that was written.
- R11: Every latch rise clears the bit count. A word sent after a rejected word is accepted, and a second latch rise with no bits in between is ignored.
- R12: The reserved bits 11:10 have no effect on which register is written or on what it receives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the controller, asynchronous |
| sda_i | input | 1 | Serial data, most significant bit first |
| latch_i | input | 1 | Commit strobe, acting on its rising edge |
| deemph_o | output | 2 | De-emphasis selection |
| fmt_o | output | 3 | Serial input format |
| width_o | output | 2 | Word width |
| pdown_o | output | 1 | Power-down |
| interp_o | output | 2 | Interpolation ratio |
| mute_o | output | 6 | Per-channel mute |
| vol_o | output | 60 | Six packed 10-bit volumes |
| replicate_o | output | 1 | Copy channel-1 stereo to channels 2 and 3 |
| mclk_sel_o | output | 2 | Master clock multiplier select |
| zero_pol_o | output | 1 | Zero-flag polarity |
| tdm_slave_o | output | 1 | TDM clock direction, 1 = slave |
| wr_stb_o | output | 1 | One-cycle pulse per accepted write |
| wr_addr_o | output | 4 | Address of the accepted write |

## Verification
The hardest case to reach from the ports is a latch rise that arrives with the wrong bit count. A valid-looking word then has to leave every register and the strobe untouched. That includes the count left over when a latch rises with no bits after a good write.

The bench reaches these cases by driving the serial pins bit by bit with an explicit bit count: 15 bits, 17 bits and 0 bits. In each case it compares all outputs against a model, and only then sends a correct word.

The same routine also sweeps all sixteen addresses and walks a single one across the payload of every register. This checks each field's bit position against values computed in the bench.

// File: rtl/dac_cfg_pkg.sv
package dac_cfg_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 10;
  localparam int WORD_W = 16;
  localparam int NCH    = 6;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTL1 = 4'd0,
    RA_CTL2 = 4'd1,
    RA_VOL1 = 4'd2,
    RA_VOL6 = 4'd7,
    RA_CTL3 = 4'd8
  } reg_addr_e;

  typedef struct packed {
    logic       replicate;
    logic [1:0] mclk_sel;
    logic       zero_pol;
    logic       tdm_slave;
  } ctl3_t;
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] s1_q, s2_q, prev_q;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          s1_q[i]   <= 1'b0;
          s2_q[i]   <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          s1_q[i]   <= d_i[i];
          s2_q[i]   <= s1_q[i];
          prev_q[i] <= s2_q[i];
        end
      end
      assign rise_o[i] = s2_q[i] & ~prev_q[i];
    end
  endgenerate

  assign q_o = s2_q;
endmodule

// File: rtl/dcp_shifter.sv
module dcp_shifter #(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              bit_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (bit_en_i) begin
      sh_d = {sh_q[WORD_W-2:0], bit_i};
      if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
    if (clr_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign word_o = sh_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_FULL);

  // R11: a latch rise always leaves the counter at zero
  a_r11_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
  // R3: the count saturates one past a full word and never wraps
  a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_OVER);
endmodule

// File: rtl/dcp_regbank.sv
module dcp_regbank
  import dac_cfg_pkg::*;
#(
  parameter int NUM_CH = NCH,
  parameter int VOL_W  = DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       data_i,
  output logic [DATA_W-1:0]       ctl1_o,
  output logic [NUM_CH-1:0]       mute_o,
  output logic [NUM_CH*VOL_W-1:0] vol_o,
  output ctl3_t                   ctl3_o,
  output logic                    wr_stb_o,
  output logic [ADDR_W-1:0]       wr_addr_o
);
  localparam logic [VOL_W-1:0] VOL_RST = {VOL_W{1'b1}};

  logic                   acc;
  logic                   en_c1, en_c2, en_c3;
  logic [NUM_CH-1:0]      en_vol;
  logic [DATA_W-1:0]      c1_q, c1_d;
  logic [NUM_CH-1:0]      mu_q, mu_d;
  ctl3_t                  c3_q, c3_d;
  logic [NUM_CH-1:0][VOL_W-1:0] vol_q, vol_d;
  logic                   stb_q;
  logic [ADDR_W-1:0]      sa_q, sa_d;

  assign acc   = commit_i && (addr_i <= RA_CTL3);
  assign en_c1 = acc && (addr_i == RA_CTL1);
  assign en_c2 = acc && (addr_i == RA_CTL2);
  assign en_c3 = acc && (addr_i == RA_CTL3);

  always_comb begin
    c1_d = en_c1 ? data_i : c1_q;
    mu_d = en_c2 ? data_i[NUM_CH-1:0] : mu_q;
    c3_d = c3_q;
    if (en_c3) begin
      c3_d.replicate = data_i[5];
      c3_d.mclk_sel  = data_i[4:3];
      c3_d.zero_pol  = data_i[2];
      c3_d.tdm_slave = data_i[0];
    end
    sa_d = acc ? addr_i : sa_q;
  end

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_vol
      assign en_vol[k] = acc && (addr_i == ADDR_W'(int'(RA_VOL1) + k));
      assign vol_d[k]  = en_vol[k] ? data_i[VOL_W-1:0] : vol_q[k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vol_q[k] <= VOL_RST;
        else        vol_q[k] <= vol_d[k];
      end
      assign vol_o[k*VOL_W +: VOL_W] = vol_q[k];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q  <= '0;
      mu_q  <= '0;
      c3_q  <= '0;
      stb_q <= 1'b0;
      sa_q  <= '0;
    end else begin
      c1_q  <= c1_d;
      mu_q  <= mu_d;
      c3_q  <= c3_d;
      stb_q <= acc;
      sa_q  <= sa_d;
    end
  end

  assign ctl1_o    = c1_q;
  assign mute_o    = mu_q;
  assign ctl3_o    = c3_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = sa_q;

  // R2: no commit, no change in any stored field
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(c1_q) && $stable(mu_q) && $stable(c3_q) && $stable(vol_q)));
  // R4: a reserved address leaves the bank untouched
  a_r4_rsv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && addr_i > RA_CTL3) |=> ($stable(c1_q) && $stable(vol_q) && !wr_stb_o));
  // R7: a volume write changes only one channel
  a_r7_one_vol: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(en_vol));
endmodule

// File: rtl/dac_cfg_port.sv
module dac_cfg_port
  import dac_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        latch_i,
  output logic [1:0]  deemph_o,
  output logic [2:0]  fmt_o,
  output logic [1:0]  width_o,
  output logic        pdown_o,
  output logic [1:0]  interp_o,
  output logic [5:0]  mute_o,
  output logic [59:0] vol_o,
  output logic        replicate_o,
  output logic [1:0]  mclk_sel_o,
  output logic        zero_pol_o,
  output logic        tdm_slave_o,
  output logic        wr_stb_o,
  output logic [3:0]  wr_addr_o
);
  localparam int CNT_W = $clog2(WORD_W + 2);

  logic [2:0]        pin_q, pin_rise;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;
  logic              full, commit;
  logic [DATA_W-1:0] c1;
  ctl3_t             c3;
  logic              unused_rsv;

  dcp_sync #(.W(3)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({latch_i, sda_i, scl_i}),
    .q_o    (pin_q),
    .rise_o (pin_rise)
  );

  dcp_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en_i (pin_rise[0]),
    .bit_i    (pin_q[1]),
    .clr_i    (pin_rise[2]),
    .word_o   (word),
    .cnt_o    (cnt),
    .full_o   (full)
  );

  assign commit     = pin_rise[2] & full;
  assign unused_rsv = ^{word[11:10], pin_rise[1]};

  dcp_regbank #(.NUM_CH(NCH), .VOL_W(DATA_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit),
    .addr_i    (word[WORD_W-1 -: ADDR_W]),
    .data_i    (word[DATA_W-1:0]),
    .ctl1_o    (c1),
    .mute_o    (mute_o),
    .vol_o     (vol_o),
    .ctl3_o    (c3),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o)
  );

  assign deemph_o    = c1[9:8];
  assign fmt_o       = c1[7:5];
  assign width_o     = c1[4:3];
  assign pdown_o     = c1[2];
  assign interp_o    = c1[1:0];
  assign replicate_o = c3.replicate;
  assign mclk_sel_o  = c3.mclk_sel;
  assign zero_pol_o  = c3.zero_pol;
  assign tdm_slave_o = c3.tdm_slave;

  // R3: a strobe follows only a cycle in which the count stood at a full word
  a_r3_count16: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> ($past(cnt) == CNT_W'(WORD_W)));
  // R4: strobed addresses are never reserved ones
  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> (wr_addr_o <= 4'd8));
  // R10: the strobe lasts a single cycle
  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);
endmodule

// File: tb/dac_cfg_port_tb.sv
module dac_cfg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b0, sda = 1'b0, latch = 1'b0;
  logic [1:0] deemph, width, interp, mclk_sel;
  logic [2:0] fmt;
  logic pdown, replicate, zero_pol, tdm_slave, wr_stb;
  logic [5:0] mute;
  logic [59:0] vol;
  logic [3:0] wr_addr;

  int checks = 0, errors = 0, stb_cnt = 0;
  logic [3:0] last_addr = '0;

  logic [9:0] m_c1, m_c3;
  logic [5:0] m_mu;
  logic [9:0] m_vol [6];

  always #10 clk = ~clk;

  dac_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .latch_i(latch),
    .deemph_o(deemph), .fmt_o(fmt), .width_o(width), .pdown_o(pdown),
    .interp_o(interp), .mute_o(mute), .vol_o(vol), .replicate_o(replicate),
    .mclk_sel_o(mclk_sel), .zero_pol_o(zero_pol), .tdm_slave_o(tdm_slave),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr)
  );

  always @(negedge clk) if (rst_n && wr_stb) begin
    stb_cnt++;
    last_addr = wr_addr;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({deemph, fmt, width, pdown, interp} == m_c1, {req, " R5"}, "ctl1 fields",
        64'({deemph, fmt, width, pdown, interp}), 64'(m_c1));
    chk(mute == m_mu, {req, " R6"}, "mute", 64'(mute), 64'(m_mu));
    for (int k = 0; k < 6; k++)
      chk(vol[k*10 +: 10] == m_vol[k], {req, " R7"}, $sformatf("vol ch%0d", k+1),
          64'(vol[k*10 +: 10]), 64'(m_vol[k]));
    chk({replicate, mclk_sel, zero_pol, tdm_slave} ==
        {m_c3[5], m_c3[4:3], m_c3[2], m_c3[0]}, {req, " R8"}, "ctl3 fields",
        64'({replicate, mclk_sel, zero_pol, tdm_slave}),
        64'({m_c3[5], m_c3[4:3], m_c3[2], m_c3[0]}));
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); scl = 1'b0; sda = (i < 16) ? w[i] : 1'b1;
      repeat (2) @(negedge clk);
      scl = 1'b1;
      repeat (2) @(negedge clk);
    end
    @(negedge clk); scl = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_latch();
    @(negedge clk); latch = 1'b1;
    repeat (8) @(negedge clk);
    latch = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] w, input int nbits, input string req);
    int prev;
    bit ok_write;
    prev = stb_cnt;
    ok_write = (nbits == 16) && (w[15:12] <= 4'd8);
    send_bits(w, nbits);
    pulse_latch();
    if (ok_write) begin
      case (w[15:12])
        4'd0: m_c1 = w[9:0];
        4'd1: m_mu = w[5:0];
        4'd8: m_c3 = w[9:0];
        default: m_vol[w[15:12] - 2] = w[9:0];
      endcase
      chk(stb_cnt == prev + 1 && last_addr == w[15:12], {req, " R10"}, "strobe count/addr",
          64'({stb_cnt - prev, last_addr}), 64'({32'd1, w[15:12]}));
    end else begin
      chk(stb_cnt == prev, {req, " R4 R3"}, "no strobe", 64'(stb_cnt - prev), 64'd0);
    end
    check_all(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_c1 = '0; m_c3 = '0; m_mu = '0;
    for (int k = 0; k < 6; k++) m_vol[k] = 10'h3FF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_stb, "R9", "strobe at reset", 64'(wr_stb), 64'd0);
    check_all("R9");

    // R1 R4 R12: every address with varying payload and reserved bits
    for (int a = 0; a < 16; a++) begin
      logic [9:0] d;
      d = 10'((a * 97 + 13) & 10'h3FF);
      do_write({4'(a), 2'(a), d}, 16, "R1 R12");
    end

    // R5-R8: walking one through each register payload
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 10; b++)
        do_write({4'(a), 2'b00, 10'(1 << b)}, 16, "R1");

    // R2: shift a full word without latching, outputs must hold
    send_bits({4'd0, 2'b00, 10'h155}, 16);
    check_all("R2");
    pulse_latch();
    m_c1 = 10'h155;
    check_all("R2");

    // R3: wrong counts ignored
    do_write({4'd2, 2'b00, 10'h0AA}, 15, "R3 short");
    do_write({4'd3, 2'b00, 10'h0BB}, 17, "R3 long");
    // R11: counter cleared, next good word accepted; bare latch ignored
    do_write({4'd8, 2'b11, 10'h03D}, 16, "R11");
    do_write({4'd8, 2'b00, 10'h000}, 0, "R11 bare");
    do_write({4'd1, 2'b00, 10'h3FF}, 16, "R6 R11");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule